// File: doc/BRIEF.md
# Inbound Memory-Write Burst Translator

This block sits behind a PCIe receive path. It turns each decoded memory write request into one burst write on an on-chip memory-mapped master port. A request arrives as a header followed by its payload. The header carries the bus address, the length in dwords, the first and last dword byte enables, a vector of which base-address windows were hit, and a malformed flag. The payload follows as 64-bit beats that are already aligned to qword lanes.

In endpoint mode, the lowest-numbered window that was hit picks a translation entry. That entry is fixed when the block is configured and holds a local base and a window size. The local address is the base plus the offset of the request inside the window. In root-port mode, the window vector is ignored and the bus address is passed through to the single master.

Some requests are discarded, and their payload is drained so that the stream stays aligned:
- Malformed requests and endpoint requests that hit no window are discarded silently.
- Requests whose byte enables are not contiguous, or not aligned to their size, are discarded and raise a one-cycle error strobe.

Top module: `pcie_wr_xlat`

## Requirements
- R1: Each accepted request produces exactly one burst. Its burst count is (A2 + len + 1) / 2 beats, where A2 is bit 2 of the bus address and len is the dword length. The payload beats appear on the write data in arrival order, one master beat per payload beat.
- R2: In endpoint mode the lowest-index set bit of the window-hit vector selects an entry. The local byte address is base + (bus address mod 2^winlog2). The master address is that value with bits 2:0 cleared. With the defaults the entries are: entry 0 base 0x10000000, window 2^20; entry 1 base 0x20000000, window 2^12; entry 2 base 0x30000000, window 2^16.
- R3: In root-port mode the local address is the bus address itself, with bits 2:0 cleared, whatever the window-hit vector holds.
- R4: A request with the malformed flag set produces no master beat and no error strobe. Its payload beats are still consumed.
- R5: For a one-dword request, the first byte enable must be one of 0x1, 0x2, 0x4, 0x8, 0x3, 0xC or 0xF, and the last byte enable must be 0x0.
- R6: For a request of two or more dwords, the first byte enable must be 0xF, 0xE, 0xC or 0x8, and the last byte enable must be 0x1, 0x3, 0x7 or 0xF. A length of 0 is illegal.
- R7: A request that breaks R5 or R6 produces no master beat and its payload is consumed. The error strobe goes high for exactly one cycle, in the cycle after the header is accepted.
- R8: Dword k of the request sits in lane position A2 + k. Beat b carries position 2b on byte enables 3:0 and position 2b+1 on byte enables 7:4. Dword 0 uses the first byte enable, the final dword uses the last byte enable, and dwords in between use 0xF. Positions with no dword get 0x0.
- R9: While the master write is high and the wait request is asserted, the address, burst count, byte enables and data hold, and no payload beat is taken.
- R10: In endpoint mode a request that hits no window is discarded silently, like a malformed one.
- R11: After reset the master write and the error strobe are low and the header ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_root_port | input | 1 | 1 selects root-port mode, 0 selects endpoint mode |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted when high together with hdr_valid |
| hdr_addr | input | ADDR_W | Bus byte address |
| hdr_len | input | LEN_W | Length in dwords |
| hdr_first_be | input | 4 | First dword byte enables |
| hdr_last_be | input | 4 | Last dword byte enables |
| hdr_bar_hit | input | NUM_BAR | Window-hit vector |
| hdr_malformed | input | 1 | Packet flagged malformed |
| pl_valid | input | 1 | Payload beat present |
| pl_ready | output | 1 | Payload beat taken when high together with pl_valid |
| pl_data | input | 64 | Payload beat |
| m_write | output | 1 | Master write request |
| m_address | output | LADDR_W | Local qword-aligned byte address |
| m_burstcount | output | LEN_W | Beats in the burst |
| m_byteenable | output | 8 | Byte enables of the current beat |
| m_writedata | output | 64 | Data of the current beat |
| m_waitrequest | input | 1 | Master stall |
| err_be | output | 1 | One-cycle strobe for a byte-enable violation |

## Verification
The error strobe is due in the cycle after the edge that accepts the header. A master beat appears one edge after the edge that takes its payload beat, and it stays until an edge at which the wait request is low. The bench samples every output on the falling edge. It counts only the beats present there with the wait request low, so a beat is counted on the cycle it is actually transferred, whatever the stall pattern. After each request the bench waits a fixed number of cycles, longer than the worst stall, before it compares the collected beats, addresses, enables and strobes against the values computed from the requirements.

// File: rtl/pcie_wr_xlat_pkg.sv
package pcie_wr_xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } xlat_state_e;

  // Byte-enable legality: contiguous lanes, aligned to the access size.
  function automatic logic be_legal(input logic single,
                                    input logic [3:0] fbe,
                                    input logic [3:0] lbe);
    if (single)
      return (lbe == 4'h0) &&
             (fbe inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF});
    else
      return (fbe inside {4'hF, 4'hE, 4'hC, 4'h8}) &&
             (lbe inside {4'h1, 4'h3, 4'h7, 4'hF});
  endfunction

endpackage

// File: rtl/pcie_wr_xlat_map.sv
module pcie_wr_xlat_map #(
  parameter int NUM_BAR = 3,
  parameter int ADDR_W  = 32,
  parameter int LADDR_W = 32,
  parameter logic [NUM_BAR-1:0][LADDR_W-1:0] BAR_BASE =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_BAR-1:0][5:0] BAR_WIN_LOG2 = {6'd16, 6'd12, 6'd20}
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_BAR-1:0] bar_hit,
  input  logic               root_port,
  output logic [LADDR_W-1:0] local_addr,
  output logic               addr_ok
);

  logic [NUM_BAR-1:0][LADDR_W-1:0] cand;
  logic [LADDR_W-1:0]              ep_addr;

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_win
    localparam logic [ADDR_W-1:0] WMASK =
      (ADDR_W'(1) << BAR_WIN_LOG2[i]) - ADDR_W'(1);
    assign cand[i] = BAR_BASE[i] + LADDR_W'(bus_addr & WMASK);
  end

  // Lowest index wins when several windows report a hit.
  always_comb begin
    ep_addr = '0;
    for (int i = NUM_BAR - 1; i >= 0; i--)
      if (bar_hit[i]) ep_addr = cand[i];
  end

  assign local_addr = root_port ? LADDR_W'(bus_addr) : ep_addr;
  assign addr_ok    = root_port | (|bar_hit);

endmodule

// File: rtl/pcie_wr_xlat_beat_be.sv
module pcie_wr_xlat_beat_be #(
  parameter int LEN_W = 10
) (
  input  logic             start_odd,
  input  logic [LEN_W-1:0] len,
  input  logic [3:0]       first_be,
  input  logic [3:0]       last_be,
  input  logic [LEN_W-1:0] beat_idx,
  output logic [7:0]       beat_be
);

  localparam int KW = LEN_W + 2;

  logic signed [KW-1:0] k_lo;
  logic signed [KW-1:0] len_s;

  assign len_s = $signed({2'b00, len});
  assign k_lo  = $signed({1'b0, beat_idx, 1'b0}) - $signed(KW'(start_odd));

  // One decoder per dword lane of the qword beat.
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic signed [KW-1:0] k;
    logic [3:0]           be_l;
    assign k = k_lo + $signed(KW'(ln));
    always_comb begin
      if (k < 0 || k >= len_s) be_l = 4'h0;
      else if (k == 0)         be_l = first_be;
      else if (k == len_s - 1) be_l = last_be;
      else                     be_l = 4'hF;
    end
    assign beat_be[ln*4 +: 4] = be_l;
  end

endmodule

// File: rtl/pcie_wr_xlat.sv
module pcie_wr_xlat
  import pcie_wr_xlat_pkg::*;
#(
  parameter int NUM_BAR = 3,
  parameter int ADDR_W  = 32,
  parameter int LADDR_W = 32,
  parameter int LEN_W   = 10,
  parameter logic [NUM_BAR-1:0][LADDR_W-1:0] BAR_BASE =
    {32'h3000_0000, 32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_BAR-1:0][5:0] BAR_WIN_LOG2 = {6'd16, 6'd12, 6'd20}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_root_port,
  input  logic               hdr_valid,
  output logic               hdr_ready,
  input  logic [ADDR_W-1:0]  hdr_addr,
  input  logic [LEN_W-1:0]   hdr_len,
  input  logic [3:0]         hdr_first_be,
  input  logic [3:0]         hdr_last_be,
  input  logic [NUM_BAR-1:0] hdr_bar_hit,
  input  logic               hdr_malformed,
  input  logic               pl_valid,
  output logic               pl_ready,
  input  logic [63:0]        pl_data,
  output logic               m_write,
  output logic [LADDR_W-1:0] m_address,
  output logic [LEN_W-1:0]   m_burstcount,
  output logic [7:0]         m_byteenable,
  output logic [63:0]        m_writedata,
  input  logic               m_waitrequest,
  output logic               err_be
);

  xlat_state_e        state;
  logic [LADDR_W-1:0] map_addr;
  logic               map_ok;
  logic [LEN_W:0]     beats_w;
  logic               drop_quiet, drop_err, hdr_take;

  logic [LADDR_W-1:0] r_addr;
  logic               r_odd;
  logic [LEN_W-1:0]   r_len, r_beats, r_idx;
  logic [3:0]         r_fbe, r_lbe;
  logic [7:0]         cur_be;
  logic               slot_free, pl_take, last_idx;

  pcie_wr_xlat_map #(
    .NUM_BAR(NUM_BAR), .ADDR_W(ADDR_W), .LADDR_W(LADDR_W),
    .BAR_BASE(BAR_BASE), .BAR_WIN_LOG2(BAR_WIN_LOG2)
  ) u_map (
    .bus_addr  (hdr_addr),
    .bar_hit   (hdr_bar_hit),
    .root_port (cfg_root_port),
    .local_addr(map_addr),
    .addr_ok   (map_ok)
  );

  pcie_wr_xlat_beat_be #(.LEN_W(LEN_W)) u_be (
    .start_odd(r_odd),
    .len      (r_len),
    .first_be (r_fbe),
    .last_be  (r_lbe),
    .beat_idx (r_idx),
    .beat_be  (cur_be)
  );

  assign beats_w    = ({1'b0, hdr_len} + (LEN_W+1)'(hdr_addr[2]) + (LEN_W+1)'(1)) >> 1;
  assign drop_quiet = hdr_malformed | ~map_ok;
  assign drop_err   = ~drop_quiet &
                      ((hdr_len == '0) | ~be_legal(hdr_len == LEN_W'(1), hdr_first_be, hdr_last_be));

  assign hdr_ready = (state == ST_IDLE);
  assign hdr_take  = hdr_valid & hdr_ready;
  assign slot_free = ~m_write | ~m_waitrequest;
  assign pl_ready  = ((state == ST_XFER) & slot_free) | (state == ST_DRAIN);
  assign pl_take   = pl_valid & pl_ready;
  assign last_idx  = (r_idx == r_beats - LEN_W'(1));

  // Request sequencing and per-request context.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      err_be  <= 1'b0;
      r_addr  <= '0;
      r_odd   <= 1'b0;
      r_len   <= '0;
      r_beats <= '0;
      r_idx   <= '0;
      r_fbe   <= '0;
      r_lbe   <= '0;
    end else begin
      err_be <= hdr_take & drop_err;
      case (state)
        ST_IDLE: if (hdr_take) begin
          r_addr  <= {map_addr[LADDR_W-1:3], 3'b000};
          r_odd   <= hdr_addr[2];
          r_len   <= hdr_len;
          r_beats <= beats_w[LEN_W-1:0];
          r_idx   <= '0;
          r_fbe   <= hdr_first_be;
          r_lbe   <= hdr_last_be;
          if (beats_w == '0)                state <= ST_IDLE;
          else if (drop_quiet || drop_err)  state <= ST_DRAIN;
          else                              state <= ST_XFER;
        end
        ST_XFER, ST_DRAIN: if (pl_take) begin
          r_idx <= r_idx + LEN_W'(1);
          if (last_idx) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Registered master beat; loads only when the slot is free.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_write      <= 1'b0;
      m_address    <= '0;
      m_burstcount <= '0;
      m_byteenable <= '0;
      m_writedata  <= '0;
    end else if (pl_take && state == ST_XFER) begin
      m_write      <= 1'b1;
      m_address    <= r_addr;
      m_burstcount <= r_beats;
      m_byteenable <= cur_be;
      m_writedata  <= pl_data;
    end else if (!m_waitrequest) begin
      m_write <= 1'b0;
    end
  end

endmodule

// File: rtl/pcie_wr_xlat_chk.sv
module pcie_wr_xlat_chk #(
  parameter int LADDR_W = 32,
  parameter int LEN_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               hdr_valid,
  input logic               hdr_ready,
  input logic               m_write,
  input logic [LADDR_W-1:0] m_address,
  input logic [LEN_W-1:0]   m_burstcount,
  input logic [7:0]         m_byteenable,
  input logic [63:0]        m_writedata,
  input logic               m_waitrequest,
  input logic               err_be
);

  assert_hold_under_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (m_write && m_waitrequest) |=> (m_write && $stable(m_address) &&
      $stable(m_burstcount) && $stable(m_byteenable) && $stable(m_writedata)));

  assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    err_be |=> !err_be);

  assert_err_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_be) |-> $past(hdr_valid && hdr_ready));

  assert_qword_address_R2: assert property (@(posedge clk) disable iff (rst)
    m_write |-> (m_address[2:0] == 3'b000));

  assert_beat_has_lanes_R8: assert property (@(posedge clk) disable iff (rst)
    m_write |-> (m_byteenable != 8'h00 && m_burstcount != '0));

  always @(posedge clk) begin
    if (!rst && $past(rst))
      assert_reset_state_R11: assert (!m_write && !err_be && hdr_ready);
  end

endmodule

bind pcie_wr_xlat pcie_wr_xlat_chk #(.LADDR_W(LADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .m_write(m_write), .m_address(m_address), .m_burstcount(m_burstcount),
  .m_byteenable(m_byteenable), .m_writedata(m_writedata),
  .m_waitrequest(m_waitrequest), .err_be(err_be)
);

// File: tb/pcie_wr_xlat_tb.sv
module pcie_wr_xlat_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_root_port = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [31:0] hdr_addr = '0;
  logic [9:0]  hdr_len = '0;
  logic [3:0]  hdr_first_be = '0, hdr_last_be = '0;
  logic [2:0]  hdr_bar_hit = '0;
  logic        hdr_malformed = 1'b0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [63:0] pl_data = '0;
  logic        m_write;
  logic [31:0] m_address;
  logic [9:0]  m_burstcount;
  logic [7:0]  m_byteenable;
  logic [63:0] m_writedata;
  logic        m_waitrequest = 1'b0;
  logic        err_be;

  always #5 clk = ~clk;

  pcie_wr_xlat u_dut (
    .clk(clk), .rst(rst), .cfg_root_port(cfg_root_port),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_addr(hdr_addr),
    .hdr_len(hdr_len), .hdr_first_be(hdr_first_be), .hdr_last_be(hdr_last_be),
    .hdr_bar_hit(hdr_bar_hit), .hdr_malformed(hdr_malformed),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .m_write(m_write), .m_address(m_address), .m_burstcount(m_burstcount),
    .m_byteenable(m_byteenable), .m_writedata(m_writedata),
    .m_waitrequest(m_waitrequest), .err_be(err_be)
  );

  typedef struct packed {
    logic        rp;
    logic [31:0] addr;
    logic [9:0]  len;
    logic [3:0]  fbe;
    logic [3:0]  lbe;
    logic [2:0]  bar;
    logic        mal;
    logic [9:0]  pl_n;
    logic [9:0]  exp_n;
    logic [31:0] exp_addr;
    logic [7:0]  exp_fbe;
    logic [7:0]  exp_lbe;
    logic        exp_err;
  } vec_t;

  localparam int NV = 18;
  // 0-3,14,16: R2 endpoint mapping; 4,17: R3 root port; 5,15: R4 malformed;
  // 6-8,12,13: R5 single-dword rules; 9,10: R6 multi-dword rules; 11: R10 no hit.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h8000_1230, 10'd4,  4'hF, 4'hF, 3'b001, 1'b0, 10'd2, 10'd2, 32'h1000_1230, 8'hFF, 8'hFF, 1'b0},
    '{1'b0, 32'hC000_0FF4, 10'd3,  4'hC, 4'h3, 3'b010, 1'b0, 10'd2, 10'd2, 32'h2000_0FF0, 8'hC0, 8'h3F, 1'b0},
    '{1'b0, 32'h0000_4008, 10'd1,  4'h3, 4'h0, 3'b100, 1'b0, 10'd1, 10'd1, 32'h3000_4008, 8'h03, 8'h03, 1'b0},
    '{1'b0, 32'h0000_400C, 10'd1,  4'hC, 4'h0, 3'b100, 1'b0, 10'd1, 10'd1, 32'h3000_4008, 8'hC0, 8'hC0, 1'b0},
    '{1'b1, 32'h1234_5674, 10'd2,  4'h8, 4'h1, 3'b000, 1'b0, 10'd2, 10'd2, 32'h1234_5670, 8'h80, 8'h01, 1'b0},
    '{1'b0, 32'h0000_0100, 10'd2,  4'hF, 4'hF, 3'b001, 1'b1, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b0},
    '{1'b0, 32'h0000_0100, 10'd1,  4'h5, 4'h0, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd1,  4'h6, 4'h0, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd1,  4'h7, 4'h0, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd2,  4'h6, 4'hF, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd2,  4'hF, 4'h2, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd2,  4'hF, 4'hF, 3'b000, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b0},
    '{1'b0, 32'h0000_0100, 10'd1,  4'hF, 4'h1, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0100, 10'd1,  4'h0, 4'h0, 3'b001, 1'b0, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b1},
    '{1'b0, 32'h0000_0010, 10'd1,  4'hF, 4'h0, 3'b110, 1'b0, 10'd1, 10'd1, 32'h2000_0010, 8'h0F, 8'h0F, 1'b0},
    '{1'b1, 32'h0000_0100, 10'd2,  4'hF, 4'hF, 3'b000, 1'b1, 10'd1, 10'd0, 32'h0,         8'h00, 8'h00, 1'b0},
    '{1'b0, 32'h0000_0004, 10'd16, 4'hF, 4'hF, 3'b001, 1'b0, 10'd9, 10'd9, 32'h1000_0000, 8'hF0, 8'h0F, 1'b0},
    '{1'b1, 32'hABCD_EF00, 10'd1,  4'h1, 4'h0, 3'b111, 1'b0, 10'd1, 10'd1, 32'hABCD_EF00, 8'h01, 8'h01, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  int beat_cnt = 0;
  int err_seen = 0;
  int data_bad = 0;
  logic [31:0] cap_addr;
  logic [9:0]  cap_bc;
  logic [7:0]  cap_fbe, cap_lbe;
  logic        stall_en = 1'b0;
  int          stall_ph = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Stall pattern for R9: wait request high two cycles of every three.
  always @(posedge clk) begin
    #1;
    stall_ph = (stall_ph == 2) ? 0 : stall_ph + 1;
    m_waitrequest = stall_en && (stall_ph != 0);
  end

  // Output monitor, sampled on the falling edge.
  logic        hold_prev = 1'b0;
  logic [31:0] h_addr;
  logic [7:0]  h_be;
  logic [63:0] h_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (err_be) err_seen++;
      if (hold_prev)
        check(m_write && m_address == h_addr && m_byteenable == h_be && m_writedata == h_data,
              "R9", "hold under wait", {m_write, m_writedata[62:0]}, {1'b1, h_data[62:0]});
      hold_prev = m_write && m_waitrequest;
      h_addr = m_address; h_be = m_byteenable; h_data = m_writedata;
      if (m_write && !m_waitrequest) begin
        if (beat_cnt == 0) begin
          cap_addr = m_address; cap_bc = m_burstcount; cap_fbe = m_byteenable;
        end
        cap_lbe = m_byteenable;
        if (m_writedata != {32'(cur_t), 32'(beat_cnt)}) data_bad++;
        beat_cnt++;
      end
    end
  end

  task automatic run_vec(input int t, input vec_t v);
    @(posedge clk); #2;
    cur_t = t; beat_cnt = 0; err_seen = 0; data_bad = 0;
    cfg_root_port = v.rp; hdr_addr = v.addr; hdr_len = v.len;
    hdr_first_be = v.fbe; hdr_last_be = v.lbe; hdr_bar_hit = v.bar;
    hdr_malformed = v.mal; hdr_valid = 1'b1;
    do @(negedge clk); while (!hdr_ready);
    @(posedge clk); #2;
    hdr_valid = 1'b0;
    for (int b = 0; b < int'(v.pl_n); b++) begin
      pl_valid = 1'b1;
      pl_data = {32'(t), 32'(b)};
      do @(negedge clk); while (!pl_ready);
      @(posedge clk); #2;
    end
    pl_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(beat_cnt == int'(v.exp_n), "R1/R4/R7/R10", $sformatf("vec %0d beats", t),
          64'(beat_cnt), 64'(v.exp_n));
    check(err_seen == int'(v.exp_err), "R7", $sformatf("vec %0d err strobe", t),
          64'(err_seen), 64'(v.exp_err));
    if (v.exp_n != 0) begin
      check(cap_addr == v.exp_addr, v.rp ? "R3" : "R2", $sformatf("vec %0d address", t),
            64'(cap_addr), 64'(v.exp_addr));
      check(cap_bc == v.exp_n, "R1", $sformatf("vec %0d burstcount", t),
            64'(cap_bc), 64'(v.exp_n));
      check(cap_fbe == v.exp_fbe && cap_lbe == v.exp_lbe, "R8",
            $sformatf("vec %0d first/last enables", t),
            {48'h0, cap_fbe, cap_lbe}, {48'h0, v.exp_fbe, v.exp_lbe});
      check(data_bad == 0, "R1", $sformatf("vec %0d data order", t),
            64'(data_bad), 64'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(!m_write && !err_be && hdr_ready && !pl_ready, "R11", "reset state",
          {60'h0, m_write, err_be, hdr_ready, pl_ready}, 64'h2);

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int i = 0; i < NV; i++) run_vec(i + 32 * pass, VECS[i]);
    end

    // Corner: long burst under stalls, then back-to-back without a gap.
    stall_en = 1'b1;
    run_vec(100, VECS[16]);
    stall_en = 1'b0;
    run_vec(101, VECS[1]);
    run_vec(102, VECS[6]);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule